// File: doc/BRIEF.md
# Literal-Operand ALU Execute Unit

This unit executes the short single-word instructions that combine an 8-bit literal with an 8-bit working register W. It receives one 16-bit instruction word, qualified by a valid strobe. It decodes the operation from the upper byte of the word and commits the result one clock edge later. The registers it holds are W, a 5-bit status register, a 4-bit bank-select register and a 16-bit product register. The operations are add, subtract-from-literal, AND, inclusive OR, exclusive OR, move, unsigned multiply, bank load and return-with-literal.

Return-with-literal takes two cycles. It loads W with the literal and raises a return request, together with the literal, for one cycle. The surrounding core uses that request to pop its own stack. Any word presented during that second cycle is discarded. A word whose upper byte is not in the map leaves every register untouched and raises an illegal-opcode pulse.

Top module: `lit_alu_exec`

## Requirements
- R1: An accepted word has its operation in bits 15:8 and the literal k in bits 7:0. Upper byte 0x0F sets W to W+k, 0x0B to W AND k, 0x09 to W OR k, 0x0A to W XOR k, and 0x0E to k. The new W appears on the edge that accepts the word.
- R2: Add updates all five status bits. The bit positions are bit0 carry (C), bit1 digit carry out of bit 3 (DC), bit2 zero (Z), bit3 signed overflow (OV) and bit4 negative (N, the result's bit 7).
- R3: AND, OR and XOR update only Z and N. C, DC and OV keep their values.
- R4: Upper byte 0x08 sets W to k minus W, modulo 256. C is 1 when k >= W (no borrow). DC is 1 when k[3:0] >= W[3:0]. OV is the signed overflow of the subtraction. Z and N follow the result.
- R5: Move, multiply, return and bank load leave the status register unchanged.
- R6: Upper byte 0x0D loads the product register with the unsigned 16-bit product W*k and leaves W unchanged.
- R7: Upper byte 0x01 with bits 7:4 equal to zero loads the bank register with bits 3:0. No other register changes.
- R8: Upper byte 0x0C loads W with k and raises ret_req for exactly one cycle, with ret_lit equal to k. A word presented while ret_req is high is ignored.
- R9: Any other word, including 0x01 with nonzero bits 7:4, leaves W, status, bank and product unchanged and raises illegal for exactly one cycle.
- R10: After reset, W, status, bank, product, ret_req and illegal are all zero.
- R11: While insn_valid is low, no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| insn_valid | input | 1 | Instruction word is present |
| insn_word | input | 16 | Instruction word |
| w_out | output | 8 | Working register |
| status_out | output | 5 | Status flags: C, DC, Z, OV, N from bit0 up |
| bank_out | output | 4 | Bank-select register |
| prod_out | output | 16 | Product register, high byte in bits 15:8 |
| ret_req | output | 1 | Return request, second cycle of a return |
| ret_lit | output | 8 | Literal carried with the return request |
| illegal | output | 1 | One-cycle pulse for an unmapped word |

## Verification
The assertions assume that insn_valid and insn_word are stable around each rising edge. They also assume that the surrounding core may present a word during the return cycle and expects it to be dropped. The bench drives inputs only on falling edges. On purpose, it offers an add word during every return cycle, and it holds a live add word while valid is low. The sweeps cover every W value against a spread of literals for each arithmetic and logic operation, and every upper byte of the opcode space. Carry, digit carry and overflow are therefore exercised on both sides of each boundary.

// File: rtl/lit_alu_pkg.sv
package lit_alu_pkg;

  typedef enum logic [3:0] {
    OP_NONE,
    OP_ADD,
    OP_AND,
    OP_IOR,
    OP_XOR,
    OP_MOV,
    OP_MUL,
    OP_SUB,
    OP_RET,
    OP_BANK,
    OP_BAD
  } lit_op_e;

  localparam int FL_C  = 0;
  localparam int FL_DC = 1;
  localparam int FL_Z  = 2;
  localparam int FL_OV = 3;
  localparam int FL_N  = 4;
  localparam int FLW   = 5;

endpackage

// File: rtl/lit_decode.sv
module lit_decode
  import lit_alu_pkg::*;
#(
  parameter int DW = 8,
  parameter int BW = 4
) (
  input  logic            valid,
  input  logic [2*DW-1:0] word,
  output lit_op_e         op
);
  localparam int IW = 2 * DW;

  logic [DW-1:0] hi;
  logic [DW-1:0] lo;
  logic          bank_ok;

  assign hi      = word[IW-1:DW];
  assign lo      = word[DW-1:0];
  assign bank_ok = (lo >> BW) == '0;

  always_comb begin
    op = OP_NONE;
    if (valid) begin
      case (hi)
        8'h0F:   op = OP_ADD;
        8'h0B:   op = OP_AND;
        8'h09:   op = OP_IOR;
        8'h0A:   op = OP_XOR;
        8'h0E:   op = OP_MOV;
        8'h0D:   op = OP_MUL;
        8'h08:   op = OP_SUB;
        8'h0C:   op = OP_RET;
        8'h01:   op = bank_ok ? OP_BANK : OP_BAD;
        default: op = OP_BAD;
      endcase
    end
  end
endmodule

// File: rtl/lit_datapath.sv
module lit_datapath
  import lit_alu_pkg::*;
#(
  parameter int DW = 8,
  parameter int BW = 4
) (
  input  lit_op_e          op,
  input  logic [DW-1:0]    lit,
  input  logic [DW-1:0]    w_cur,
  input  logic [FLW-1:0]   st_cur,
  input  logic [BW-1:0]    bank_cur,
  input  logic [2*DW-1:0]  prod_cur,
  output logic [DW-1:0]    w_nx,
  output logic [FLW-1:0]   st_nx,
  output logic [BW-1:0]    bank_nx,
  output logic [2*DW-1:0]  prod_nx
);
  localparam int NW = DW / 2;

  typedef struct packed {
    logic [DW-1:0] res;
    logic          c;
    logic          dc;
    logic          ov;
  } arith_t;

  // a + b, or a + ~b + 1 when sub; carry means no borrow for sub
  function automatic arith_t arith(input logic [DW-1:0] a,
                                   input logic [DW-1:0] b,
                                   input logic sub);
    arith_t        r;
    logic [DW-1:0] bb;
    logic [DW:0]   full;
    logic [NW:0]   nib;
    bb     = sub ? ~b : b;
    full   = {1'b0, a} + {1'b0, bb} + {{DW{1'b0}}, sub};
    nib    = {1'b0, a[NW-1:0]} + {1'b0, bb[NW-1:0]} + {{NW{1'b0}}, sub};
    r.res  = full[DW-1:0];
    r.c    = full[DW];
    r.dc   = nib[NW];
    r.ov   = (a[DW-1] == bb[DW-1]) && (full[DW-1] != a[DW-1]);
    return r;
  endfunction

  function automatic logic [FLW-1:0] zn_flags(input logic [FLW-1:0] st,
                                              input logic [DW-1:0] r);
    logic [FLW-1:0] o;
    o        = st;
    o[FL_Z]  = (r == '0);
    o[FL_N]  = r[DW-1];
    return o;
  endfunction

  function automatic logic [FLW-1:0] all_flags(input arith_t a);
    logic [FLW-1:0] o;
    o        = '0;
    o[FL_C]  = a.c;
    o[FL_DC] = a.dc;
    o[FL_OV] = a.ov;
    o[FL_Z]  = (a.res == '0);
    o[FL_N]  = a.res[DW-1];
    return o;
  endfunction

  arith_t add_r;
  arith_t sub_r;
  logic [DW-1:0] and_r, ior_r, xor_r;

  assign add_r = arith(w_cur, lit, 1'b0);
  assign sub_r = arith(lit, w_cur, 1'b1);
  assign and_r = w_cur & lit;
  assign ior_r = w_cur | lit;
  assign xor_r = w_cur ^ lit;

  always_comb begin
    w_nx    = w_cur;
    st_nx   = st_cur;
    bank_nx = bank_cur;
    prod_nx = prod_cur;
    case (op)
      OP_ADD: begin w_nx = add_r.res; st_nx = all_flags(add_r); end
      OP_SUB: begin w_nx = sub_r.res; st_nx = all_flags(sub_r); end
      OP_AND: begin w_nx = and_r; st_nx = zn_flags(st_cur, and_r); end
      OP_IOR: begin w_nx = ior_r; st_nx = zn_flags(st_cur, ior_r); end
      OP_XOR: begin w_nx = xor_r; st_nx = zn_flags(st_cur, xor_r); end
      OP_MOV, OP_RET: w_nx = lit;
      OP_MUL:  prod_nx = w_cur * lit;
      OP_BANK: bank_nx = lit[BW-1:0];
      default: ;
    endcase
  end
endmodule

// File: rtl/lit_alu_exec.sv
module lit_alu_exec
  import lit_alu_pkg::*;
#(
  parameter int DW = 8,
  parameter int BW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              insn_valid,
  input  logic [2*DW-1:0]   insn_word,
  output logic [DW-1:0]     w_out,
  output logic [FLW-1:0]    status_out,
  output logic [BW-1:0]     bank_out,
  output logic [2*DW-1:0]   prod_out,
  output logic              ret_req,
  output logic [DW-1:0]     ret_lit,
  output logic              illegal
);
  localparam int PW = 2 * DW;

  logic [DW-1:0]  w_q;
  logic [FLW-1:0] st_q;
  logic [BW-1:0]  bank_q;
  logic [PW-1:0]  prod_q;
  logic           ret_q;
  logic [DW-1:0]  ret_lit_q;
  logic           ill_q;

  logic           accept;
  lit_op_e        op;
  logic [DW-1:0]  lit;
  logic [DW-1:0]  w_nx;
  logic [FLW-1:0] st_nx;
  logic [BW-1:0]  bank_nx;
  logic [PW-1:0]  prod_nx;

  // second cycle of a return blocks acceptance
  assign accept = insn_valid && !ret_q;
  assign lit    = insn_word[DW-1:0];

  lit_decode #(.DW(DW), .BW(BW)) u_dec (
    .valid (accept),
    .word  (insn_word),
    .op    (op)
  );

  lit_datapath #(.DW(DW), .BW(BW)) u_dp (
    .op       (op),
    .lit      (lit),
    .w_cur    (w_q),
    .st_cur   (st_q),
    .bank_cur (bank_q),
    .prod_cur (prod_q),
    .w_nx     (w_nx),
    .st_nx    (st_nx),
    .bank_nx  (bank_nx),
    .prod_nx  (prod_nx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w_q       <= '0;
      st_q      <= '0;
      bank_q    <= '0;
      prod_q    <= '0;
      ret_q     <= 1'b0;
      ret_lit_q <= '0;
      ill_q     <= 1'b0;
    end else begin
      w_q    <= w_nx;
      st_q   <= st_nx;
      bank_q <= bank_nx;
      prod_q <= prod_nx;
      ret_q  <= (op == OP_RET);
      ill_q  <= (op == OP_BAD);
      if (op == OP_RET) ret_lit_q <= lit;
    end
  end

  assign w_out      = w_q;
  assign status_out = st_q;
  assign bank_out   = bank_q;
  assign prod_out   = prod_q;
  assign ret_req    = ret_q;
  assign ret_lit    = ret_lit_q;
  assign illegal    = ill_q;

  AST_FLAGS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_MOV || op == OP_MUL || op == OP_RET || op == OP_BANK) |=> $stable(st_q)); // R5

  AST_MUL_W_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_MUL) |=> $stable(w_q)); // R6

  AST_SUB_NO_BORROW: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_SUB) |=> (st_q[FL_C] == ($past(lit) >= $past(w_q)))); // R4

  AST_BAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_BAD) |=> ($stable(w_q) && $stable(st_q) && $stable(bank_q)
                        && $stable(prod_q) && ill_q)); // R9

  AST_RET_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    ret_q |=> (!ret_q && $stable(w_q) && $stable(st_q))); // R8

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !insn_valid |=> ($stable(w_q) && $stable(st_q) && $stable(bank_q)
                     && $stable(prod_q) && !ill_q)); // R11

endmodule

// File: tb/sim_lit_alu_exec.sv
`timescale 1ns/1ps
module sim_lit_alu_exec;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        insn_valid = 1'b0;
  logic [15:0] insn_word = '0;
  logic [7:0]  w_out;
  logic [4:0]  status_out;
  logic [3:0]  bank_out;
  logic [15:0] prod_out;
  logic        ret_req;
  logic [7:0]  ret_lit;
  logic        illegal;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // expected state
  int ew = 0, est = 0, ebank = 0, eprod = 0, eill = 0, eret = 0;

  always #2.5 clk = ~clk;

  lit_alu_exec u0 (
    .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn_word(insn_word),
    .w_out(w_out), .status_out(status_out), .bank_out(bank_out),
    .prod_out(prod_out), .ret_req(ret_req), .ret_lit(ret_lit), .illegal(illegal)
  );

  task automatic chk(string tag, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int sgn(int v);
    return (v > 127) ? v - 256 : v;
  endfunction

  // status bits: C=1, DC=2, Z=4, OV=8, N=16
  task automatic model(int hi, int k, output string tag);
    int r, s;
    eill = 0; eret = 0;
    case (hi)
      15, 8: begin
        if (hi == 15) begin
          tag = "R2";
          r = ew + k;
          est = ((r > 255) ? 1 : 0) | ((((ew % 16) + (k % 16)) > 15) ? 2 : 0);
          s = sgn(ew) + sgn(k);
        end else begin
          tag = "R4";
          r = k - ew;
          est = ((r >= 0) ? 1 : 0) | (((k % 16) >= (ew % 16)) ? 2 : 0);
          s = sgn(k) - sgn(ew);
        end
        r = (r + 256) % 256;
        if (s > 127 || s < -128) est += 8;
        if (r == 0) est += 4;
        if (r >= 128) est += 16;
        ew = r;
      end
      11, 9, 10: begin
        tag = "R3";
        r = (hi == 11) ? (ew & k) : (hi == 9) ? (ew | k) : (ew ^ k);
        est = (est & 11) | ((r == 0) ? 4 : 0) | ((r >= 128) ? 16 : 0);
        ew = r;
      end
      14: begin tag = "R1"; ew = k; end
      13: begin tag = "R6"; eprod = ew * k; end
      12: begin tag = "R8"; ew = k; eret = 1; end
      1: begin
        if (k < 16) begin tag = "R7"; ebank = k; end
        else begin tag = "R9"; eill = 1; end
      end
      default: begin tag = "R9"; eill = 1; end
    endcase
  endtask

  task automatic compare_all(string tag);
    chk(tag, "w", w_out, ew);
    chk(tag, "status", status_out, est);
    chk(tag, "bank", bank_out, ebank);
    chk(tag, "prod", prod_out, eprod);
    chk(tag, "illegal", illegal, eill);
    chk(tag, "ret_req", ret_req, eret);
  endtask

  task automatic apply(int hi, int k);
    string tag;
    insn_word  = 16'((hi << 8) | k);
    insn_valid = 1'b1;
    model(hi, k, tag);
    @(negedge clk);
    compare_all(tag);
    if (eret) begin
      chk("R8", "ret_lit", ret_lit, k);
      // offered during the return cycle, must be dropped
      insn_word = 16'h0F11;
      @(negedge clk);
      eret = 0;
      compare_all("R8");
    end
    if (eill) begin
      insn_valid = 1'b0;
      @(negedge clk);
      chk("R9", "illegal width", illegal, 0);
      eill = 0;
    end
    insn_valid = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int ops[6] = '{15, 8, 11, 9, 10, 13};
    repeat (3) @(negedge clk);
    compare_all("R10");
    rst_n = 1'b1;
    @(negedge clk);
    compare_all("R10");

    for (int w = 0; w < 256; w++)
      for (int k = 0; k < 256; k += 17)
        for (int o = 0; o < 6; o++) begin
          apply(14, w);
          apply(ops[o], k);
        end

    // idle: a live add word with valid low must not act (R11)
    apply(14, 8'h7F);
    insn_word = 16'h0F01;
    insn_valid = 1'b0;
    repeat (3) @(negedge clk);
    compare_all("R11");

    for (int k = 0; k < 16; k++) apply(1, k);
    for (int hi = 0; hi < 256; hi++) begin
      apply(14, 8'hA5);
      apply(hi, 8'h3C);
      apply(hi, 8'h02);
    end
    apply(1, 8'h10);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule